// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block steps an integrating converter through a fixed cycle of three phases. First it zeroes the offset (auto-zero). Next it integrates the input signal for a programmed time. Last it de-integrates against the reference until a comparator reports a zero crossing. The phase lengths scale with a configuration byte. The de-integrate clock count is the conversion result. It is published together with a one-cycle ready strobe at the moment the sequencer returns to auto-zero. The analog switches and the integrator sit outside the block and follow the phase code.

An active-low end-of-conversion output is low exactly while the sequencer sits in auto-zero. It therefore falls as soon as a result is available and can serve as a data-ready interrupt. An asynchronous hold pin is synchronized and then forces auto-zero and keeps it there. A system can use it to pause conversions, for example while an input multiplexer settles. While the pin is low and the configuration is marked valid, conversions repeat without any further command.

Top module: `conv_phase_seq`

## Requirements
- R1: After synchronous reset, `phase_o` is 0 (auto-zero), `eoc_n_o` is 0, `result_rdy_o` is 0 and `result_o` is 0. The phase codes are 0 for auto-zero, 1 for integrate and 2 for de-integrate. Code 3 never appears.
- R2: `eoc_n_o` is 0 in every cycle where `phase_o` is 0, and 1 in every cycle where it is not.
- R3: A full auto-zero phase lasts (cfg_val + 1) x 2^SLICE_W clocks and is followed by integrate.
- R4: Integrate lasts (cfg_val + 1) x 2^SLICE_W clocks, using the value captured on entry, and is followed by de-integrate.
- R5: When `cmp_zero` is seen high in the k-th de-integrate cycle, the sequencer enters auto-zero at that edge. At the same edge `result_o` becomes k and `result_rdy_o` is high for exactly one cycle.
- R6: If `cmp_zero` never rises, de-integrate ends after 2^FS_LOG2 times the integrate length. The result then equals that full-scale count, with the same strobe.
- R7: Two edges after `hold_in` rises, the synchronizer has passed it on, and at the third edge the sequencer is in auto-zero. It stays there while the pin is high, with no strobe and with `result_o` unchanged. After release the auto-zero count restarts from zero, so auto-zero lasts one full length plus the two synchronizer cycles.
- R8: While `cfg_ok` is low the sequencer stays in auto-zero with its counter cleared.
- R9: With `hold_in` low and `cfg_ok` high, conversions repeat back to back with no other input.
- R10: `cmp_zero` has no effect outside de-integrate. A high level during integrate does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_in | input | 1 | Asynchronous hold pin; high forces and freezes auto-zero |
| cfg_val | input | CFG_W | Phase length setting; length = (cfg_val+1) x 2^SLICE_W clocks |
| cfg_ok | input | 1 | Configuration valid; low keeps auto-zero |
| cmp_zero | input | 1 | Comparator zero-crossing flag, used in de-integrate only |
| phase_o | output | 2 | Current phase: 0 auto-zero, 1 integrate, 2 de-integrate |
| eoc_n_o | output | 1 | End of conversion, low while in auto-zero |
| result_o | output | CFG_W+SLICE_W+FS_LOG2+1 | Last de-integrate count |
| result_rdy_o | output | 1 | One-cycle strobe when `result_o` is updated |

## Verification
The assertions take for granted that `cfg_ok` and `cfg_val` are already synchronous to `clk`. They also assume `cmp_zero` is a clean level, sampled only at clock edges. Only `hold_in` may arrive at any time. The stimulus drives every input at the falling clock edge. It changes `cfg_val` only while the sequencer is outside auto-zero and integrate, so each measured phase uses a single setting. It raises the comparator only when a given de-integrate cycle, or a given integrate window, calls for it.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cps_span.sv
module cps_span #(
  parameter int CFG_W   = 8,
  parameter int SLICE_W = 8,
  parameter int CNT_W   = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_val,
  output logic [CNT_W-1:0] span_o
);
  localparam logic [CNT_W-1:0] SPAN_MIN = CNT_W'(1) << SLICE_W;

  logic [CNT_W-1:0] steps;
  assign steps = CNT_W'(cfg_val) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) span_o <= SPAN_MIN;
    else     span_o <= steps << SLICE_W;
  end
endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
#(
  parameter int CNT_W   = 19,
  parameter int FS_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_s,
  input  logic             cfg_ok,
  input  logic             cmp_zero,
  input  logic [CNT_W-1:0] span,
  output logic [1:0]       phase_o,
  output logic             eoc_n_o,
  output logic [CNT_W-1:0] result_o,
  output logic             rdy_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             rdy_q, rdy_d;
  logic             eoc_n_q;
  logic [CNT_W-1:0] fs_lim;

  assign fs_lim = len_q << FS_LOG2;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + CNT_W'(1);
    len_d = len_q;
    res_d = res_q;
    rdy_d = 1'b0;
    if (hold_s || !cfg_ok) begin
      ph_d  = PH_AZ;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_AZ: begin
          if (cnt_q >= span - CNT_W'(1)) begin
            ph_d  = PH_INT;
            cnt_d = '0;
            len_d = span;
          end
        end
        PH_INT: begin
          if (cnt_q >= len_q - CNT_W'(1)) begin
            ph_d  = PH_DEINT;
            cnt_d = '0;
          end
        end
        PH_DEINT: begin
          if (cmp_zero || (cnt_q >= fs_lim - CNT_W'(1))) begin
            ph_d  = PH_AZ;
            cnt_d = '0;
            res_d = cnt_q + CNT_W'(1);
            rdy_d = 1'b1;
          end
        end
        default: begin
          ph_d  = PH_AZ;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_AZ;
      cnt_q   <= '0;
      len_q   <= '0;
      res_q   <= '0;
      rdy_q   <= 1'b0;
      eoc_n_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      res_q   <= res_d;
      rdy_q   <= rdy_d;
      eoc_n_q <= (ph_d != PH_AZ);
    end
  end

  assign phase_o  = ph_q;
  assign eoc_n_o  = eoc_n_q;
  assign result_o = res_q;
  assign rdy_o    = rdy_q;

  // R1: only the three defined phase codes appear
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    ph_q != 2'd3);

  // R7: a synchronized hold puts the sequencer in auto-zero at the next edge
  a_r7_hold_forces_az: assert property (@(posedge clk) disable iff (rst)
    hold_s |=> (ph_q == PH_AZ));

  // R8: an invalid configuration keeps auto-zero
  a_r8_cfg_off_az: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> (ph_q == PH_AZ));

  // R5: the ready strobe lasts a single cycle
  a_r5_rdy_single: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> !rdy_q);

  // R5: the ready strobe coincides with the move from de-integrate to auto-zero
  a_r5_rdy_on_az_entry: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (ph_q == PH_AZ) && ($past(ph_q) == PH_DEINT));

  // R4: integrate is entered only from auto-zero
  a_r4_int_after_az: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_INT) && ($past(ph_q) != PH_INT)) |-> ($past(ph_q) == PH_AZ));

  // R6: the de-integrate count never reaches the full-scale limit
  a_r6_fs_bound: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DEINT) |-> (cnt_q < fs_lim));
endmodule

// File: rtl/conv_phase_seq.sv
module conv_phase_seq #(
  parameter int CFG_W       = 8,
  parameter int SLICE_W     = 8,
  parameter int FS_LOG2     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = CFG_W + SLICE_W + FS_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_in,
  input  logic [CFG_W-1:0] cfg_val,
  input  logic             cfg_ok,
  input  logic             cmp_zero,
  output logic [1:0]       phase_o,
  output logic             eoc_n_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_rdy_o
);
  logic             hold_s;
  logic [RES_W-1:0] span;

  cps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hold_in),
    .q   (hold_s)
  );

  cps_span #(.CFG_W(CFG_W), .SLICE_W(SLICE_W), .CNT_W(RES_W)) u_span (
    .clk     (clk),
    .rst     (rst),
    .cfg_val (cfg_val),
    .span_o  (span)
  );

  cps_ctrl #(.CNT_W(RES_W), .FS_LOG2(FS_LOG2)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hold_s   (hold_s),
    .cfg_ok   (cfg_ok),
    .cmp_zero (cmp_zero),
    .span     (span),
    .phase_o  (phase_o),
    .eoc_n_o  (eoc_n_o),
    .result_o (result_o),
    .rdy_o    (result_rdy_o)
  );

  // R2: end-of-conversion is low in auto-zero
  a_r2_eoc_low_in_az: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd0) |-> !eoc_n_o);

  // R2: end-of-conversion is high outside auto-zero
  a_r2_eoc_high_else: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd0) |-> eoc_n_o);
endmodule

// File: tb/conv_phase_seq_tb.sv
module conv_phase_seq_tb;
  localparam int CFG_W   = 8;
  localparam int SLICE_W = 4;
  localparam int FS_LOG2 = 2;
  localparam int RES_W   = CFG_W + SLICE_W + FS_LOG2 + 1;
  localparam int NVEC    = 6;
  // columns: cfg value, comparator cycle (0 = never), comparator high in integrate, expected result
  localparam int VEC [NVEC][4] = '{
    '{0, 5,   0, 5},
    '{1, 1,   1, 1},
    '{2, 0,   0, 192},
    '{0, 64,  0, 64},
    '{3, 100, 1, 100},
    '{0, 0,   0, 64}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hold_in = 1'b0;
  logic [CFG_W-1:0] cfg_val = '0;
  logic             cfg_ok = 1'b0;
  logic             cmp_zero = 1'b0;
  logic [1:0]       phase_o;
  logic             eoc_n_o;
  logic [RES_W-1:0] result_o;
  logic             result_rdy_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  conv_phase_seq #(.CFG_W(CFG_W), .SLICE_W(SLICE_W), .FS_LOG2(FS_LOG2)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .hold_in      (hold_in),
    .cfg_val      (cfg_val),
    .cfg_ok       (cfg_ok),
    .cmp_zero     (cmp_zero),
    .phase_o      (phase_o),
    .eoc_n_o      (eoc_n_o),
    .result_o     (result_o),
    .result_rdy_o (result_rdy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k, bad, len, saved;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(phase_o == 2'd0, "R1", "phase in reset", phase_o, 0);
    chk(eoc_n_o == 1'b0, "R1", "eoc_n in reset", eoc_n_o, 0);
    chk(result_rdy_o == 1'b0 && result_o == '0, "R1", "result/rdy in reset",
        int'(result_o) + int'(result_rdy_o), 0);
    rst = 1'b0;

    // R8: configuration not valid keeps auto-zero
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (phase_o != 2'd0 || eoc_n_o != 1'b0) bad++;
    end
    chk(bad == 0, "R8", "cycles out of auto-zero while cfg invalid", bad, 0);
    cfg_ok = 1'b1;
    k = 0;
    @(negedge clk);
    while (phase_o == 2'd0) begin k++; @(negedge clk); end
    chk(k == 15, "R8", "auto-zero samples after cfg valid", k, 15);

    // vector table: R2 R3 R4 R5 R6 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      cfg_val = CFG_W'(VEC[v][0]);
      len = (VEC[v][0] + 1) << SLICE_W;
      while (phase_o != 2'd2) @(negedge clk);
      cmp_zero = 1'b1;
      while (phase_o != 2'd0) @(negedge clk);
      cmp_zero = 1'b0;
      while (phase_o == 2'd0) @(negedge clk);
      // integrate; R10 comparator raised here for some vectors
      k = 0; bad = 0;
      while (phase_o == 2'd1) begin
        k++;
        if (eoc_n_o != 1'b1) bad++;
        cmp_zero = (VEC[v][2] != 0);
        @(negedge clk);
      end
      cmp_zero = 1'b0;
      chk(k == len, "R4", "integrate length (R10 when comparator high)", k, len);
      chk(bad == 0, "R2", "eoc_n low during integrate", bad, 0);
      // de-integrate
      k = 0;
      while (phase_o == 2'd2) begin
        k++;
        cmp_zero = (VEC[v][1] != 0) && (k >= VEC[v][1]);
        @(negedge clk);
      end
      cmp_zero = 1'b0;
      chk(k == VEC[v][3], (VEC[v][1] == 0) ? "R6" : "R5", "de-integrate length", k, VEC[v][3]);
      chk(int'(result_o) == VEC[v][3], (VEC[v][1] == 0) ? "R6" : "R5", "result", int'(result_o), VEC[v][3]);
      chk(result_rdy_o == 1'b1, "R5", "ready strobe on auto-zero entry", result_rdy_o, 1);
      chk(eoc_n_o == 1'b0, "R2", "eoc_n falls with result", eoc_n_o, 0);
      k = 0; bad = 0;
      while (phase_o == 2'd0) begin
        k++;
        if (k >= 2 && result_rdy_o) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R5", "ready strobe longer than one cycle", bad, 0);
      chk(k == len, "R3", "auto-zero length, R9 continuous", k, len);
    end

    // R7: hold during integrate
    cfg_val = CFG_W'(3);
    len = 4 << SLICE_W;
    while (phase_o != 2'd2) @(negedge clk);
    cmp_zero = 1'b1;
    while (phase_o != 2'd0) @(negedge clk);
    cmp_zero = 1'b0;
    while (phase_o == 2'd0) @(negedge clk);
    saved = int'(result_o);
    hold_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(phase_o == 2'd1, "R7", "phase before hold passes synchronizer", phase_o, 1);
    @(negedge clk);
    chk(phase_o == 2'd0, "R7", "phase three edges after hold", phase_o, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      cmp_zero = i[0];
      @(negedge clk);
      if (phase_o != 2'd0 || result_rdy_o || eoc_n_o) bad++;
    end
    cmp_zero = 1'b0;
    chk(bad == 0, "R7", "cycles not frozen in auto-zero", bad, 0);
    chk(int'(result_o) == saved, "R7", "result during hold", int'(result_o), saved);
    hold_in = 1'b0;
    k = 0;
    @(negedge clk);
    while (phase_o == 2'd0) begin k++; @(negedge clk); end
    chk(k == len + 1, "R7", "auto-zero samples after release", k, len + 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule